// File: doc/BRIEF.md
# Pin Bank with Per-Pin Edge and Level Interrupts

This block is a bank of general-purpose pins behind a small 32-bit register bus. Software uses it to drive pins, to sample them, and to take interrupts from them. Each pin has four configuration bits: one enables sampling, one enables the output driver, one sets the level to drive, and one inverts that level. Each pin drives its own interrupt line.

Incoming pad levels pass through a two-flop synchronizer. The synchronized value is then masked by the pin's input enable. The block watches every pin for four conditions: a rising edge, a falling edge, a high level and a low level. A condition that is seen sets a sticky pending bit, whether or not that condition is enabled. Software clears a pending bit by writing a 1 to it. A pin's interrupt line is high while any of its pending bits is set together with the matching enable bit.

Register word offsets (byte address): sampled value 0x00, sample enable 0x04, driver enable 0x08, drive level 0x0C, invert 0x40. The four conditions use enable/pending pairs at 0x18/0x1C (rise), 0x20/0x24 (fall), 0x28/0x2C (high) and 0x30/0x34 (low). Bit n of every register belongs to pin n. Address bits [1:0] are ignored.

Top module: `gpio_irq_bank`

## Requirements
- R1: While reset is asserted, pad_oe, pad_out, pin_irq and bus_rdata are all zero. Every enable, drive level, invert bit and pending bit resets to zero.
- R2: pad_oe equals the driver-enable register. pad_out equals (drive level XOR invert) AND driver enable, bit by bit, from the cycle after the write.
- R3: Offset 0x00 reads pad_in delayed by two flops and ANDed with the sample-enable register. It is read-only.
- R4: The rise pending bit (0x1C) of a pin sets in the cycle after its masked sample goes from 0 to 1. It stays set until it is cleared.
- R5: The fall pending bit (0x24) of a pin sets in the cycle after its masked sample goes from 1 to 0. It stays set until it is cleared.
- R6: The high pending bit (0x2C) sets every cycle the masked sample is 1, and the low pending bit (0x34) sets every cycle it is 0. A disabled input samples as 0, so its low pending bit sets soon after reset. A level bit cleared while its level still holds sets again.
- R7: Writing to a pending register clears exactly the bits written as 1. Bits written as 0 keep their value.
- R8: When a detection and a clear hit the same pending bit in the same cycle, the bit ends up set.
- R9: pin_irq[n] is the OR over the four conditions of (pending[n] AND enable[n]). Pending bits set even while their enable bit is 0.
- R10: A read strobe captures data into bus_rdata at the clock edge, and bus_rdata holds it until the next strobe. Unmapped offsets read as zero.
- R11: Every writable register reads back the value last written to it, in bits [PINS-1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| pad_in | input | PINS | Asynchronous pad levels |
| pad_out | output | PINS | Driven pad levels |
| pad_oe | output | PINS | Pad driver enables |
| pin_irq | output | PINS | One interrupt line per pin |

## Verification
The bench builds the block with its defaults: PINS = 32 and AW = 7. Every register is therefore a full 32-bit word, and bit 31 of each register is exercised along with the others. The 7-bit address reaches the invert register at 0x40 as well as unmapped holes such as 0x10 and 0x3C. Random pad activity on all 32 pins produces edges and level conditions together. This lets the bench hit same-cycle set-versus-clear collisions on many pins at once.

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int PINS = 32,
  parameter int AW   = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [31:0]     bus_wdata,
  input  logic            bus_re,
  output logic [31:0]     bus_rdata,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe,
  output logic [PINS-1:0] pin_irq
);

  localparam int WW = AW - 2;
  localparam logic [WW-1:0] W_IN   = WW'(0);
  localparam logic [WW-1:0] W_IEN  = WW'(1);
  localparam logic [WW-1:0] W_OEN  = WW'(2);
  localparam logic [WW-1:0] W_OVAL = WW'(3);
  localparam logic [WW-1:0] W_XOR  = WW'(16);
  localparam int COND_BASE = 6;

  logic [WW-1:0]   widx;
  logic [PINS-1:0] wdat;
  logic [PINS-1:0] in_en_q, out_en_q, out_val_q, out_xor_q;
  logic [PINS-1:0] sync1_q, sync2_q, prev_q, inp;
  logic [3:0][PINS-1:0] ie_q, ip_q, det, hit;
  logic [31:0] rsel;
  logic unused_ok;

  assign widx = bus_addr[AW-1:2];
  assign wdat = bus_wdata[PINS-1:0];
  assign unused_ok = ^{bus_addr[1:0], bus_wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_en_q   <= '0;
      out_en_q  <= '0;
      out_val_q <= '0;
      out_xor_q <= '0;
    end else if (bus_we) begin
      if (widx == W_IEN)  in_en_q   <= wdat;
      if (widx == W_OEN)  out_en_q  <= wdat;
      if (widx == W_OVAL) out_val_q <= wdat;
      if (widx == W_XOR)  out_xor_q <= wdat;
    end
  end

  assign pad_oe  = out_en_q;
  assign pad_out = (out_val_q ^ out_xor_q) & out_en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      prev_q  <= inp;
    end
  end

  assign inp    = sync2_q & in_en_q;
  assign det[0] = inp & ~prev_q;
  assign det[1] = ~inp & prev_q;
  assign det[2] = inp;
  assign det[3] = ~inp;

  for (genvar k = 0; k < 4; k++) begin : g_cond
    localparam logic [WW-1:0] W_IE = WW'(COND_BASE + 2 * k);
    localparam logic [WW-1:0] W_IP = WW'(COND_BASE + 2 * k + 1);
    logic [PINS-1:0] clr;
    assign clr = (bus_we && widx == W_IP) ? wdat : '0;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ie_q[k] <= '0;
        ip_q[k] <= '0;
      end else begin
        if (bus_we && widx == W_IE) ie_q[k] <= wdat;
        ip_q[k] <= (ip_q[k] & ~clr) | det[k];
      end
    end

    assign hit[k] = ip_q[k] & ie_q[k];
  end

  assign pin_irq = hit[0] | hit[1] | hit[2] | hit[3];

  always_comb begin
    rsel = '0;
    case (widx)
      W_IN:    rsel[PINS-1:0] = inp;
      W_IEN:   rsel[PINS-1:0] = in_en_q;
      W_OEN:   rsel[PINS-1:0] = out_en_q;
      W_OVAL:  rsel[PINS-1:0] = out_val_q;
      W_XOR:   rsel[PINS-1:0] = out_xor_q;
      default: ;
    endcase
    for (int k = 0; k < 4; k++) begin
      if (widx == WW'(COND_BASE + 2 * k))     rsel[PINS-1:0] = ie_q[k];
      if (widx == WW'(COND_BASE + 2 * k + 1)) rsel[PINS-1:0] = ip_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rsel;
  end

  // R4: rise flags never drop without a write to their register
  a_r4_rise_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && widx == WW'(COND_BASE + 1))
      |=> ((ip_q[0] & $past(ip_q[0])) == $past(ip_q[0])));

  // R5: fall flags never drop without a write to their register
  a_r5_fall_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && widx == WW'(COND_BASE + 3))
      |=> ((ip_q[1] & $past(ip_q[1])) == $past(ip_q[1])));

  // R6: a high sample is always recorded in the high flags
  a_r6_high_sets: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ip_q[2] & $past(inp)) == $past(inp)));

  // R8: a rising detection survives a simultaneous clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && widx == WW'(COND_BASE + 1))
      |=> ((ip_q[0] & $past(det[0])) == $past(det[0])));

  // R10: holes in the map read as zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && (widx == WW'(4) || widx == WW'(5) || widx == WW'(14) || widx == WW'(15)))
      |=> (bus_rdata == 32'd0));

endmodule

// File: tb/gpio_irq_bank_bench.sv
module gpio_irq_bank_bench;
  localparam int PINS = 32;
  localparam int AW   = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [PINS-1:0] pad_in = '0;
  logic [PINS-1:0] pad_out, pad_oe, pin_irq;

  int checks = 0;
  int errors = 0;
  logic [AW-1:0] last_raddr = '0;

  always #10 clk = ~clk;

  gpio_irq_bank #(.PINS(PINS), .AW(AW)) u_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pin_irq(pin_irq));

  // reference model built from the requirements
  logic [31:0] m_s1, m_s2, m_prev, m_ien, m_oen, m_oval, m_xor, m_rd;
  logic [31:0] m_ie [4];
  logic [31:0] m_ip [4];
  logic [31:0] m_inp;
  assign m_inp = m_s2 & m_ien;

  function automatic logic [31:0] m_det(int k);
    case (k)
      0: return m_inp & ~m_prev;
      1: return ~m_inp & m_prev;
      2: return m_inp;
      default: return ~m_inp;
    endcase
  endfunction

  function automatic logic [31:0] m_read(logic [AW-1:0] a);
    int w;
    w = int'(a[AW-1:2]);
    case (w)
      0: return m_inp;
      1: return m_ien;
      2: return m_oen;
      3: return m_oval;
      16: return m_xor;
      6, 8, 10, 12: return m_ie[(w - 6) / 2];
      7, 9, 11, 13: return m_ip[(w - 7) / 2];
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_ien <= '0; m_oen <= '0;
      m_oval <= '0; m_xor <= '0; m_rd <= '0;
      for (int k = 0; k < 4; k++) begin m_ie[k] <= '0; m_ip[k] <= '0; end
    end else begin
      m_s1 <= pad_in; m_s2 <= m_s1; m_prev <= m_inp;
      if (bus_we) begin
        case (int'(bus_addr[AW-1:2]))
          1: m_ien <= bus_wdata;
          2: m_oen <= bus_wdata;
          3: m_oval <= bus_wdata;
          16: m_xor <= bus_wdata;
          default: ;
        endcase
      end
      for (int k = 0; k < 4; k++) begin
        if (bus_we && int'(bus_addr[AW-1:2]) == 6 + 2 * k) m_ie[k] <= bus_wdata;
        m_ip[k] <= (m_ip[k] & ~((bus_we && int'(bus_addr[AW-1:2]) == 7 + 2 * k) ? bus_wdata : 32'd0)) | m_det(k);
      end
      if (bus_re) m_rd <= m_read(bus_addr);
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string rd_tag(logic [AW-1:0] a);
    case (int'(a[AW-1:2]))
      0: return "R3 input read";
      7: return "R4 rise pending";
      9: return "R5 fall pending";
      11, 13: return "R6 level pending";
      1, 2, 3, 6, 8, 10, 12, 16: return "R11 readback";
      default: return "R10 unmapped read";
    endcase
  endfunction

  task automatic check_all();
    logic [31:0] irq_exp;
    irq_exp = '0;
    for (int k = 0; k < 4; k++) irq_exp |= m_ip[k] & m_ie[k];
    chk("R2 pad_oe", pad_oe, m_oen);
    chk("R2 pad_out", pad_out, (m_oval ^ m_xor) & m_oen);
    chk("R9 pin_irq", pin_irq, irq_exp);
    chk(rd_tag(last_raddr), bus_rdata, m_rd);
  endtask

  task automatic step(logic we, logic [AW-1:0] a, logic [31:0] d, logic re);
    bus_we = we; bus_addr = a; bus_wdata = d; bus_re = re;
    if (re) last_raddr = a;
    @(negedge clk);
    check_all();
    bus_we = 1'b0; bus_re = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, string req, logic [31:0] exp);
    step(1'b0, a, '0, 1'b1);
    chk(req, bus_rdata, exp);
  endtask

  function automatic logic [AW-1:0] pick_addr(int n);
    case (n % 15)
      0: return 7'h00;  1: return 7'h04;  2: return 7'h08;  3: return 7'h0C;
      4: return 7'h18;  5: return 7'h1C;  6: return 7'h20;  7: return 7'h24;
      8: return 7'h28;  9: return 7'h2C;  10: return 7'h30; 11: return 7'h34;
      12: return 7'h40; 13: return 7'h10; default: return 7'h3C;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 pad_oe", pad_oe, '0);
    chk("R1 pad_out", pad_out, '0);
    chk("R1 pin_irq", pin_irq, '0);
    chk("R1 rdata", bus_rdata, '0);
    rst_n = 1'b1;
    rd(7'h1C, "R1 rise pending after reset", 32'd0);
    rd(7'h30, "R1 low enable after reset", 32'd0);

    // R2: output path with inversion
    step(1'b1, 7'h0C, 32'hF0F0_1234, 1'b0);
    step(1'b1, 7'h08, 32'hFFFF_0000, 1'b0);
    step(1'b1, 7'h40, 32'h8000_00FF, 1'b0);
    chk("R2 inverted drive", pad_out, (32'hF0F0_1234 ^ 32'h8000_00FF) & 32'hFFFF_0000);

    // R3/R4: sample path and rising edge
    step(1'b1, 7'h04, 32'hFFFF_FFFF, 1'b0);
    step(1'b1, 7'h1C, 32'hFFFF_FFFF, 1'b0);
    pad_in = 32'hA5A5_0001;
    repeat (4) step(1'b0, 7'h00, '0, 1'b0);
    rd(7'h00, "R3 synced input", 32'hA5A5_0001);
    rd(7'h1C, "R4 rise latched", 32'hA5A5_0001);

    // R7: write-one-to-clear, zeros ignored
    step(1'b1, 7'h1C, 32'h0000_0000, 1'b0);
    rd(7'h1C, "R7 zero write keeps", 32'hA5A5_0001);
    step(1'b1, 7'h1C, 32'h0000_FFFF, 1'b0);
    rd(7'h1C, "R7 partial clear", 32'hA5A5_0000);

    // R8/R6: clear of a held high level loses to the set
    step(1'b1, 7'h2C, 32'hFFFF_FFFF, 1'b0);
    rd(7'h2C, "R8 set wins over clear", 32'hA5A5_0001);

    // R5/R9: falling edge with enable off then on
    pad_in = 32'h0000_0000;
    repeat (4) step(1'b0, 7'h00, '0, 1'b0);
    rd(7'h24, "R5 fall latched", 32'hA5A5_0001);
    chk("R9 no irq while disabled", pin_irq, 32'd0);
    step(1'b1, 7'h20, 32'h0000_0001, 1'b0);
    chk("R9 irq on enabled fall", pin_irq, 32'h0000_0001);
    rd(7'h10, "R10 hole reads zero", 32'd0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic we, re;
      logic [AW-1:0] a;
      logic [31:0] d;
      we = ($urandom % 10) < 3;
      re = ($urandom % 2) == 1;
      a = pick_addr(int'($urandom % 15));
      d = $urandom;
      if ((a == 7'h1C || a == 7'h24 || a == 7'h2C || a == 7'h34) && ($urandom % 2 == 1))
        d = 32'hFFFF_FFFF;
      pad_in = pad_in ^ ($urandom & $urandom & $urandom);
      step(we, a, d, re);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule